// File: doc/BRIEF.md
# Selectable Serial Line Encoder

This block converts a serial transmit bit stream into one of eight line codes picked by a 3-bit code input. A bit-rate strobe marks the start of each bit cell and a strobe at twice the bit rate marks half-cell boundaries. The same registered output path produces every code, from plain and inverted levels through the transition codes to four biphase variants. The biphase variants are two frequency-modulation codes, Manchester and differential Manchester.

The code input is taken into the block only while the frame-active input is low. Changing the selector during a frame therefore has no effect until the transmitter goes idle again. After reset the line rests at 1. The transition-based codes work relative to the level the block drove last.

The cell-start strobe `bitEn` must be asserted in the same cycle as `halfEn`. A `halfEn` pulse without `bitEn` marks the middle of the cell. The line changes on the clock edge that samples a strobe and holds its value at every other edge.

Top module: `line_encoder`

## Requirements
- R1: After reset `lineOut` is 1, and it stays 1 until the first strobe.
- R2: Code 3'b000 drives the data bit unchanged for the whole cell.
- R3: Code 3'b001 drives the inverse of the data bit for the whole cell.
- R4: Code 3'b010 toggles the line at cell start for a 1 bit and holds it for a 0 bit.
- R5: Code 3'b011 toggles the line at cell start for a 0 bit and holds it for a 1 bit.
- R6: Code 3'b100 toggles the line at every cell start, and toggles it again at mid-cell only for a 1 bit.
- R7: Code 3'b101 toggles the line at every cell start, and toggles it again at mid-cell only for a 0 bit.
- R8: Code 3'b110 drives the data bit in the first half-cell and its complement in the second half-cell.
- R9: Code 3'b111 toggles the line at every mid-cell, and toggles it at cell start only for a 0 bit.
- R10: `modeSel` is captured only in cycles where `frameActive` is 0. A change made while `frameActive` is 1 does not alter the code in use.
- R11: `lineOut` changes only on the clock edge after a cycle with `bitEn` or `halfEn` high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Line code selector |
| frameActive | input | 1 | High while a frame is in progress; freezes the selected code |
| bitEn | input | 1 | Bit-rate strobe, marks a cell start (asserted together with halfEn) |
| halfEn | input | 1 | Twice-bit-rate strobe; alone it marks mid-cell |
| dataIn | input | 1 | Serial data bit, sampled at cell start |
| lineOut | output | 1 | Encoded line level |

## Verification
A wrong latched code shows at the ports on the first strobe after the frame starts. The line then takes a level or transition that belongs to another code. A wrong stored line level makes every transition code inverted from that edge onward. A bad held data bit shows as a wrong mid-cell transition half a cell after the cell starts. The bench checks the line after every strobe and in the quiet cycle that follows it, so any such fault appears within two clocks.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;

  typedef enum logic [2:0] {
    CODE_NRZ        = 3'b000,
    CODE_NRZB       = 3'b001,
    CODE_NRZI_MARK  = 3'b010,
    CODE_NRZI_SPACE = 3'b011,
    CODE_FM1        = 3'b100,
    CODE_FM0        = 3'b101,
    CODE_MANCH      = 3'b110,
    CODE_DMANCH     = 3'b111
  } lineCode_e;

  typedef struct packed {
    logic cellStart;
    logic midCell;
    logic dataBit;
  } encStrobe_t;

endpackage

// File: rtl/enc_ctrl.sv
module enc_ctrl
  import line_enc_pkg::*;
#(
  parameter lineCode_e RESET_CODE = CODE_NRZ
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       frameActive,
  input  logic       bitEn,
  input  logic       halfEn,
  input  logic       dataIn,
  output encStrobe_t strobe,
  output lineCode_e  curMode
);

  // Code is captured only while idle
  always_ff @(posedge clk) begin
    if (!rstN)             curMode <= RESET_CODE;
    else if (!frameActive) curMode <= lineCode_e'(modeSel);
  end

  always_comb begin
    strobe.cellStart = bitEn;
    strobe.midCell   = halfEn && !bitEn;
    strobe.dataBit   = dataIn;
  end

  // R10: a frame in progress freezes the code in use
  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameActive |=> $stable(curMode));

endmodule

// File: rtl/enc_datapath.sv
module enc_datapath
  import line_enc_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  encStrobe_t strobe,
  input  lineCode_e  curMode,
  output logic       lineOut
);

  logic lineQ, heldBit, nextLine;

  always_comb begin
    nextLine = lineQ;
    if (strobe.cellStart) begin
      unique case (curMode)
        CODE_NRZ:        nextLine = strobe.dataBit;
        CODE_NRZB:       nextLine = !strobe.dataBit;
        CODE_NRZI_MARK:  nextLine = strobe.dataBit ? !lineQ : lineQ;
        CODE_NRZI_SPACE: nextLine = strobe.dataBit ? lineQ : !lineQ;
        CODE_FM1,
        CODE_FM0:        nextLine = !lineQ;
        CODE_MANCH:      nextLine = strobe.dataBit;
        CODE_DMANCH:     nextLine = strobe.dataBit ? lineQ : !lineQ;
        default:         nextLine = lineQ;
      endcase
    end else if (strobe.midCell) begin
      unique case (curMode)
        CODE_FM1:    nextLine = heldBit ? !lineQ : lineQ;
        CODE_FM0:    nextLine = heldBit ? lineQ : !lineQ;
        CODE_MANCH:  nextLine = !heldBit;
        CODE_DMANCH: nextLine = !lineQ;
        default:     nextLine = lineQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ   <= IDLE_LEVEL;
      heldBit <= 1'b0;
    end else begin
      lineQ <= nextLine;
      if (strobe.cellStart) heldBit <= strobe.dataBit;
    end
  end

  assign lineOut = lineQ;

  // R11: no strobe, no movement
  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cellStart || strobe.midCell) |=> $stable(lineOut));

  // R6, R7: FM codes always move at cell start
  p_fm_start_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cellStart && (curMode == CODE_FM1 || curMode == CODE_FM0)
    |=> lineOut != $past(lineOut));

  // R2: plain code copies the data bit
  p_nrz_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cellStart && curMode == CODE_NRZ |=> lineOut == $past(strobe.dataBit));

  // R8, R9: both Manchester forms move at mid-cell
  p_manch_mid_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.midCell && (curMode == CODE_MANCH || curMode == CODE_DMANCH)
    |=> lineOut != $past(lineOut));

endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import line_enc_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       frameActive,
  input  logic       bitEn,
  input  logic       halfEn,
  input  logic       dataIn,
  output logic       lineOut
);

  encStrobe_t strobe;
  lineCode_e  curMode;

  enc_ctrl #(.RESET_CODE(CODE_NRZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .frameActive(frameActive),
    .bitEn(bitEn), .halfEn(halfEn), .dataIn(dataIn),
    .strobe(strobe), .curMode(curMode)
  );

  enc_datapath #(.IDLE_LEVEL(IDLE_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curMode(curMode), .lineOut(lineOut)
  );

  // R1: reset leaves the line at its idle level
  p_reset_level_r1: assert property (@(posedge clk)
    !rstN |=> lineOut == IDLE_LEVEL);

endmodule

// File: tb/line_encoder_tb.sv
module line_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic frameActive = 1'b0, bitEn = 1'b0, halfEn = 1'b0, dataIn = 1'b0;
  logic lineOut;

  int errors = 0, checks = 0, cycles = 0;
  logic refLine = 1'b1;
  logic refBit  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_encoder u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .frameActive(frameActive),
    .bitEn(bitEn), .halfEn(halfEn), .dataIn(dataIn), .lineOut(lineOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected levels taken from the requirement text
  function automatic logic startLevel(input logic [2:0] c, input logic d, input logic p);
    case (c)
      3'b000: return d;
      3'b001: return !d;
      3'b010: return d ? !p : p;
      3'b011: return d ? p : !p;
      3'b100, 3'b101: return !p;
      3'b110: return d;
      default: return d ? p : !p;
    endcase
  endfunction

  function automatic logic midLevel(input logic [2:0] c, input logic b, input logic p);
    case (c)
      3'b100: return b ? !p : p;
      3'b101: return b ? p : !p;
      3'b110: return !b;
      3'b111: return !p;
      default: return p;
    endcase
  endfunction

  task automatic startFrame(input logic [2:0] c);
    frameActive = 1'b0; modeSel = c;
    @(negedge clk);
    frameActive = 1'b1;
  endtask

  // One bit cell: four clocks, checks after each strobe and in the quiet cycle
  task automatic sendBit(input logic [2:0] effCode, input logic d, input string tag);
    dataIn = d; bitEn = 1'b1; halfEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0; halfEn = 1'b0; dataIn = !d;
    refLine = startLevel(effCode, d, refLine); refBit = d;
    check({tag, " start"}, lineOut, refLine);
    @(negedge clk);
    check("R11 hold first half", lineOut, refLine);
    halfEn = 1'b1;
    @(negedge clk);
    halfEn = 1'b0;
    refLine = midLevel(effCode, refBit, refLine);
    check({tag, " mid"}, lineOut, refLine);
    @(negedge clk);
    check("R11 hold second half", lineOut, refLine);
  endtask

  task automatic runCode(input logic [2:0] c, input logic [7:0] pat, input string tag);
    startFrame(c);
    for (int i = 7; i >= 0; i--) sendBit(c, pat[i], tag);
    frameActive = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset level", lineOut, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 idle after reset", lineOut, 1'b1);
    refLine = 1'b1;
  endtask

  task automatic testFrozenMode();
    startFrame(3'b001);
    sendBit(3'b001, 1'b1, "R10 before change");
    modeSel = 3'b000;
    @(negedge clk);
    sendBit(3'b001, 1'b1, "R10 frozen NRZB");
    sendBit(3'b001, 1'b0, "R10 frozen NRZB");
    frameActive = 1'b0;
    @(negedge clk);
    frameActive = 1'b1;
    sendBit(3'b000, 1'b1, "R10 new code after idle");
    frameActive = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    runCode(3'b000, 8'b1011_0010, "R2 NRZ");
    runCode(3'b001, 8'b1100_1010, "R3 NRZB");
    runCode(3'b010, 8'b1101_0011, "R4 NRZI mark");
    runCode(3'b011, 8'b0010_1100, "R5 NRZI space");
    runCode(3'b100, 8'b1110_0100, "R6 FM1");
    runCode(3'b101, 8'b0001_1011, "R7 FM0");
    runCode(3'b110, 8'b1010_0110, "R8 Manchester");
    runCode(3'b111, 8'b0110_1001, "R9 diff Manchester");
    testFrozenMode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule